// File: doc/BRIEF.md
# Virtual Supervisor Interrupt Register Pair

This block keeps two 64-bit machine-level registers, one per interrupt cause: a virtual enable register and a virtual pending register. From these registers, the hardware pending inputs and the delegation inputs, it forms the pending vector that supervisor level sees. If a cause is delegated, supervisor level sees the hardware pending bit. If a cause is not delegated but its virtual enable bit is set, supervisor level sees the machine-written virtual pending bit instead. This lets machine software inject interrupts into supervisor level without handing the cause over.

Every bit follows write-any-read-legal rules. Parameters decide which bits keep what software writes, which bits are fixed at zero and which are fixed at one. The low thirteen cause positions are reserved, except for the software, timer and external positions (1, 5, 9). Software finds the legal set by writing all ones and reading the register back. A single CSR port reaches both registers. In wide mode one access covers all 64 bits. In narrow mode the low half and the high half of each register sit at separate addresses. The CSR port is a plain single-cycle register port with no handshake: it never stalls, so there is no back-pressure. A write takes effect at the next clock edge, and reads are combinational.

Top module: `vsip_regs`

## Requirements
- R1: After reset the pending register reads zero, and the enable register reads zero everywhere except the fixed-one bits (default bits 35:32), which read one.
- R2: Enable bits 0, 2, 3, 4, 6, 7, 8, 10, 11 and 12 always read zero. Enable bits 1 and 9 keep written values (defaults SW_EN_WR=1, EXT_EN_WR=1).
- R3: Enable bit 5 is writable only when the timer hardware pending bit is writable (parameter TMR_HW_WR). Otherwise it reads zero; the default is 0.
- R4: Each enable bit from 13 to 63 is writable, fixed one or fixed zero. Defaults: writable 31:13 and 63:48, fixed one 35:32, others zero. Writing all ones to the enable register reads back 64'hFFFF000FFFFFE202.
- R5: Pending bits 1, 5 and 9 are writable. Pending bits 13..63 are writable per parameter (default all). All other pending bits read zero, so writing all ones reads back 64'hFFFFFFFFFFFFE222.
- R6: A wide access (csr_wide=1) writes or reads all 64 bits of one register. csr_addr[1]=0 selects the enable register and 1 selects the pending register; csr_addr[0] is ignored.
- R7: A narrow access (csr_wide=0) uses csr_addr 0=enable low, 1=enable high, 2=pending low, 3=pending high. It writes csr_wdata[31:0] into that half only, and a read returns the half in csr_rdata[31:0] with csr_rdata[63:32]=0.
- R8: sup_pend[i] = hw_pend[i] when deleg[i]=1. It equals the virtual pending bit when deleg[i]=0 and enable bit i is 1. Otherwise it is 0.
- R9: A write becomes visible on csr_rdata and sup_pend after the next rising clock edge and not before.
- R10: With csr_en=0 or csr_we=0, no register changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| csr_en | input | 1 | Access strobe |
| csr_we | input | 1 | Write when set, read otherwise |
| csr_wide | input | 1 | 1 = 64-bit access, 0 = 32-bit half access |
| csr_addr | input | 2 | Register / half select |
| csr_wdata | input | 64 | Write data |
| csr_rdata | output | 64 | Combinational read data |
| hw_pend | input | 64 | Hardware pending bits per cause |
| deleg | input | 64 | Delegation bits per cause |
| sup_pend | output | 64 | Supervisor-visible pending vector |

## Verification
On every cycle the assertions check three things. A register half loads exactly its legal bits when written. The other half and idle registers hold their value. A narrow access strobes only one half. They also check that delegated causes follow the hardware inputs, and that a cause that is neither delegated nor enabled never shows as pending. Only the bench scenarios show the actual legal masks that the parameters produce, the fixed-one reset value, how halves combine across addresses, and the merge of hardware and virtual pending bits under mixed delegation patterns.

// File: rtl/vsip_pkg.sv
package vsip_pkg;
  localparam int unsigned NCAUSE = 64;
  localparam int unsigned HALF   = NCAUSE / 2;
  localparam logic [NCAUSE-1:0] LOW_RSV = 64'h0000_0000_0000_1FFF;
  localparam int unsigned SW_BIT  = 1;
  localparam int unsigned TMR_BIT = 5;
  localparam int unsigned EXT_BIT = 9;

  typedef enum logic [1:0] {
    SEL_EN_LO = 2'd0,
    SEL_EN_HI = 2'd1,
    SEL_PV_LO = 2'd2,
    SEL_PV_HI = 2'd3
  } csr_sel_e;

  function automatic logic [NCAUSE-1:0] one_hot(input int unsigned idx, input bit on);
    logic [NCAUSE-1:0] v;
    v = '0;
    if (on) v[idx] = 1'b1;
    return v;
  endfunction
endpackage

// File: rtl/vsip_warl_reg.sv
module vsip_warl_reg #(
  parameter int unsigned W = 64,
  parameter logic [W-1:0] WR_MASK  = '0,
  parameter logic [W-1:0] RO1_MASK = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         we_lo,
  input  logic         we_hi,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] q
);
  localparam int unsigned HW = W / 2;
  localparam logic [W-1:0] LIVE = WR_MASK & ~RO1_MASK;

  logic [HW-1:0] store_h [2];

  for (genvar h = 0; h < 2; h++) begin : g_half
    logic we_h;
    assign we_h = (h == 0) ? we_lo : we_hi;
    always_ff @(posedge clk) begin
      if (!rst_n) store_h[h] <= '0;
      else if (we_h) store_h[h] <= wdata[h*HW +: HW] & LIVE[h*HW +: HW];
    end
  end

  assign q = ({store_h[1], store_h[0]} & LIVE) | RO1_MASK;

  a_r1_reset_value: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> q == RO1_MASK);
  a_r6_low_load: assert property (@(posedge clk) disable iff (!rst_n)
    we_lo |=> q[HW-1:0] == (($past(wdata[HW-1:0]) & LIVE[HW-1:0]) | RO1_MASK[HW-1:0]));
  a_r6_high_load: assert property (@(posedge clk) disable iff (!rst_n)
    we_hi |=> q[W-1:HW] == (($past(wdata[W-1:HW]) & LIVE[W-1:HW]) | RO1_MASK[W-1:HW]));
  a_r7_high_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (we_lo && !we_hi) |=> q[W-1:HW] == $past(q[W-1:HW]));
  a_r7_low_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (we_hi && !we_lo) |=> q[HW-1:0] == $past(q[HW-1:0]));
  a_r10_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!we_lo && !we_hi) |=> $stable(q));
endmodule

// File: rtl/vsip_csr_decode.sv
module vsip_csr_decode
  import vsip_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              csr_en,
  input  logic              csr_we,
  input  logic              csr_wide,
  input  logic [1:0]        csr_addr,
  input  logic [NCAUSE-1:0] csr_wdata,
  input  logic [NCAUSE-1:0] en_q,
  input  logic [NCAUSE-1:0] pv_q,
  output logic              en_we_lo,
  output logic              en_we_hi,
  output logic              pv_we_lo,
  output logic              pv_we_hi,
  output logic [NCAUSE-1:0] wr_data,
  output logic [NCAUSE-1:0] csr_rdata
);
  logic     acc;
  csr_sel_e sel;
  logic [NCAUSE-1:0] picked;

  assign acc = csr_en & csr_we;
  assign sel = csr_sel_e'(csr_addr);

  always_comb begin
    en_we_lo = 1'b0;
    en_we_hi = 1'b0;
    pv_we_lo = 1'b0;
    pv_we_hi = 1'b0;
    if (acc) begin
      if (csr_wide) begin
        en_we_lo = ~csr_addr[1];
        en_we_hi = ~csr_addr[1];
        pv_we_lo = csr_addr[1];
        pv_we_hi = csr_addr[1];
      end else begin
        unique case (sel)
          SEL_EN_LO: en_we_lo = 1'b1;
          SEL_EN_HI: en_we_hi = 1'b1;
          SEL_PV_LO: pv_we_lo = 1'b1;
          SEL_PV_HI: pv_we_hi = 1'b1;
        endcase
      end
    end
  end

  assign wr_data = csr_wide ? csr_wdata : {csr_wdata[HALF-1:0], csr_wdata[HALF-1:0]};

  assign picked = csr_addr[1] ? pv_q : en_q;

  always_comb begin
    if (csr_wide)          csr_rdata = picked;
    else if (csr_addr[0])  csr_rdata = {{HALF{1'b0}}, picked[NCAUSE-1:HALF]};
    else                   csr_rdata = {{HALF{1'b0}}, picked[HALF-1:0]};
  end

  a_r7_single_half: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && !csr_wide) |-> $onehot({en_we_lo, en_we_hi, pv_we_lo, pv_we_hi}));
  a_r6_both_halves: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && csr_wide) |-> $countones({en_we_lo, en_we_hi, pv_we_lo, pv_we_hi}) == 2);
  a_r10_no_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    !acc |-> !(en_we_lo || en_we_hi || pv_we_lo || pv_we_hi));
endmodule

// File: rtl/vsip_sup_view.sv
module vsip_sup_view
  import vsip_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NCAUSE-1:0] hw_pend,
  input  logic [NCAUSE-1:0] deleg,
  input  logic [NCAUSE-1:0] en_q,
  input  logic [NCAUSE-1:0] pv_q,
  output logic [NCAUSE-1:0] sup_pend
);
  for (genvar i = 0; i < NCAUSE; i++) begin : g_cause
    always_comb begin
      if (deleg[i])     sup_pend[i] = hw_pend[i];
      else if (en_q[i]) sup_pend[i] = pv_q[i];
      else              sup_pend[i] = 1'b0;
    end
  end

  a_r8_deleg_follow: assert property (@(posedge clk) disable iff (!rst_n)
    ((sup_pend ^ hw_pend) & deleg) == '0);
  a_r8_closed_cause: assert property (@(posedge clk) disable iff (!rst_n)
    (sup_pend & ~deleg & ~en_q) == '0);
  a_r8_virtual_only: assert property (@(posedge clk) disable iff (!rst_n)
    (sup_pend & ~deleg & ~pv_q) == '0);
endmodule

// File: rtl/vsip_regs.sv
module vsip_regs
  import vsip_pkg::*;
#(
  parameter bit SW_EN_WR  = 1'b1,
  parameter bit EXT_EN_WR = 1'b1,
  parameter bit TMR_HW_WR = 1'b0,
  parameter logic [63:0] EN_HI_WR  = 64'hFFFF_0000_FFFF_E000,
  parameter logic [63:0] EN_HI_RO1 = 64'h0000_000F_0000_0000,
  parameter logic [63:0] PV_HI_WR  = 64'hFFFF_FFFF_FFFF_E000
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        csr_en,
  input  logic        csr_we,
  input  logic        csr_wide,
  input  logic [1:0]  csr_addr,
  input  logic [63:0] csr_wdata,
  output logic [63:0] csr_rdata,
  input  logic [63:0] hw_pend,
  input  logic [63:0] deleg,
  output logic [63:0] sup_pend
);
  localparam logic [NCAUSE-1:0] EN_RO1 = EN_HI_RO1 & ~LOW_RSV;
  localparam logic [NCAUSE-1:0] EN_WR  =
      one_hot(SW_BIT, SW_EN_WR) | one_hot(TMR_BIT, TMR_HW_WR) | one_hot(EXT_BIT, EXT_EN_WR)
    | (EN_HI_WR & ~LOW_RSV & ~EN_RO1);
  localparam logic [NCAUSE-1:0] PV_WR  =
      one_hot(SW_BIT, 1'b1) | one_hot(TMR_BIT, 1'b1) | one_hot(EXT_BIT, 1'b1)
    | (PV_HI_WR & ~LOW_RSV);

  logic en_we_lo, en_we_hi, pv_we_lo, pv_we_hi;
  logic [NCAUSE-1:0] wr_data, en_q, pv_q;

  vsip_csr_decode u_dec (
    .clk(clk), .rst_n(rst_n), .csr_en(csr_en), .csr_we(csr_we), .csr_wide(csr_wide),
    .csr_addr(csr_addr), .csr_wdata(csr_wdata), .en_q(en_q), .pv_q(pv_q),
    .en_we_lo(en_we_lo), .en_we_hi(en_we_hi), .pv_we_lo(pv_we_lo), .pv_we_hi(pv_we_hi),
    .wr_data(wr_data), .csr_rdata(csr_rdata)
  );

  vsip_warl_reg #(.W(NCAUSE), .WR_MASK(EN_WR), .RO1_MASK(EN_RO1)) u_en (
    .clk(clk), .rst_n(rst_n), .we_lo(en_we_lo), .we_hi(en_we_hi), .wdata(wr_data), .q(en_q)
  );

  vsip_warl_reg #(.W(NCAUSE), .WR_MASK(PV_WR), .RO1_MASK('0)) u_pv (
    .clk(clk), .rst_n(rst_n), .we_lo(pv_we_lo), .we_hi(pv_we_hi), .wdata(wr_data), .q(pv_q)
  );

  vsip_sup_view u_view (
    .clk(clk), .rst_n(rst_n), .hw_pend(hw_pend), .deleg(deleg),
    .en_q(en_q), .pv_q(pv_q), .sup_pend(sup_pend)
  );

  a_r2_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (en_q & LOW_RSV & ~64'h222) == '0);
  a_r5_pend_reserved: assert property (@(posedge clk) disable iff (!rst_n)
    (pv_q & LOW_RSV & ~64'h222) == '0);
endmodule

// File: tb/sim_vsip_regs.sv
module sim_vsip_regs;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        csr_en = 1'b0, csr_we = 1'b0, csr_wide = 1'b0;
  logic [1:0]  csr_addr = '0;
  logic [63:0] csr_wdata = '0, hw_pend = '0, deleg = '0;
  logic [63:0] csr_rdata, sup_pend;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  localparam logic [63:0] EN_RST  = 64'h0000_000F_0000_0000;
  localparam logic [63:0] EN_ALL  = 64'hFFFF_000F_FFFF_E202;
  localparam logic [63:0] PV_ALL  = 64'hFFFF_FFFF_FFFF_E222;

  always #2.5 clk = ~clk;

  vsip_regs u0 (
    .clk(clk), .rst_n(rst_n), .csr_en(csr_en), .csr_we(csr_we), .csr_wide(csr_wide),
    .csr_addr(csr_addr), .csr_wdata(csr_wdata), .csr_rdata(csr_rdata),
    .hw_pend(hw_pend), .deleg(deleg), .sup_pend(sup_pend)
  );

  task automatic chk(input string req, input logic [63:0] got, input logic [63:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic wr(input bit wide, input logic [1:0] a, input logic [63:0] d);
    @(negedge clk);
    csr_en = 1'b1; csr_we = 1'b1; csr_wide = wide; csr_addr = a; csr_wdata = d;
    @(negedge clk);
    csr_en = 1'b0; csr_we = 1'b0; csr_wdata = '0;
  endtask

  task automatic rd(input bit wide, input logic [1:0] a, output logic [63:0] d);
    csr_wide = wide; csr_addr = a; #1;
    d = csr_rdata;
  endtask

  function automatic logic [63:0] sip_model(input logic [63:0] h, input logic [63:0] dl,
                                            input logic [63:0] e, input logic [63:0] p);
    return (dl & h) | (~dl & e & p);
  endfunction

  task automatic t_reset();
    logic [63:0] v;
    @(negedge clk);
    rd(1, 2'd0, v); chk("R1 enable reset", v, EN_RST);
    rd(1, 2'd2, v); chk("R1 pending reset", v, 64'h0);
    chk("R1 sup_pend reset", sup_pend, 64'h0);
  endtask

  task automatic t_probe();
    logic [63:0] v;
    wr(1, 2'd0, '1);
    rd(1, 2'd0, v); chk("R4 R6 enable probe", v, EN_ALL);
    chk("R2 reserved low enable", v & 64'h1FFF, 64'h202);
    chk("R3 timer enable zero", {63'h0, v[5]}, 64'h0);
    wr(1, 2'd3, '1);
    rd(1, 2'd2, v); chk("R5 R6 pending probe", v, PV_ALL);
    wr(1, 2'd1, '0);
    rd(1, 2'd0, v); chk("R4 fixed one kept", v, EN_RST);
  endtask

  task automatic t_split();
    logic [63:0] v;
    wr(0, 2'd0, 64'hDEAD_0000_FFFF_FFFF);
    rd(1, 2'd0, v); chk("R7 low half write", v, 64'h0000_000F_FFFF_E202);
    rd(0, 2'd1, v); chk("R7 high half read", v, 64'h0000_0000_0000_000F);
    rd(0, 2'd0, v); chk("R7 low half read", v, 64'h0000_0000_FFFF_E202);
    @(negedge clk);
    csr_en = 1'b1; csr_we = 1'b1; csr_wide = 1'b0; csr_addr = 2'd1; csr_wdata = 64'h0000_0000_1234_5678;
    #1; csr_en = 1'b0; csr_we = 1'b0; csr_wide = 1'b1; csr_addr = 2'd0; #1;
    chk("R9 not before edge", csr_rdata, 64'h0000_000F_FFFF_E202);
    csr_en = 1'b1; csr_we = 1'b1; csr_wide = 1'b0; csr_addr = 2'd1;
    @(negedge clk);
    csr_en = 1'b0; csr_we = 1'b0;
    rd(1, 2'd0, v); chk("R7 R9 high half write", v, 64'h1234_000F_FFFF_E202);
    wr(0, 2'd2, 64'h0000_0000_0000_0022);
    rd(1, 2'd2, v); chk("R7 pending low only", v, 64'hFFFF_FFFF_0000_0022);
  endtask

  task automatic t_nowrite();
    logic [63:0] v;
    @(negedge clk);
    csr_en = 1'b1; csr_we = 1'b0; csr_wide = 1'b1; csr_addr = 2'd2; csr_wdata = '0;
    @(negedge clk);
    csr_en = 1'b0; csr_we = 1'b1;
    @(negedge clk);
    csr_we = 1'b0;
    rd(1, 2'd2, v); chk("R10 pending untouched", v, 64'hFFFF_FFFF_0000_0022);
    rd(1, 2'd0, v); chk("R10 enable untouched", v, 64'h1234_000F_FFFF_E202);
  endtask

  task automatic t_sip();
    logic [63:0] e, p;
    wr(1, 2'd0, 64'h0000_0000_0000_2202);
    wr(1, 2'd2, 64'h0000_0001_0000_2020);
    rd(1, 2'd0, e); rd(1, 2'd2, p);
    hw_pend = 64'hA5A5_A5A5_A5A5_A5A5; deleg = '1; #1;
    chk("R8 all delegated", sup_pend, hw_pend);
    deleg = '0; #1;
    chk("R8 none delegated", sup_pend, 64'h0000_0001_0000_2000);
    chk("R8 model none", sup_pend, sip_model(hw_pend, deleg, e, p));
    deleg = 64'h0000_0000_0000_2003; hw_pend = 64'h0; #1;
    chk("R8 mixed", sup_pend, sip_model(hw_pend, deleg, e, p));
    wr(1, 2'd2, 64'h0000_0000_0000_0202);
    chk("R8 R9 after pend write", sup_pend, 64'h0000_0000_0000_0200);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    t_reset();
    t_probe();
    t_split();
    t_nowrite();
    t_sip();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule